// File: doc/BRIEF.md
# Phase Word Generator for a Sine/Cosine Oscillator

This block produces the address word that drives a sine/cosine lookup table. Two 32-bit frequency words are summed: a base tuning word and a trim word. The trim word can be switched out of the sum. The sum feeds a 32-bit phase accumulator that wraps modulo 2^32. The upper 16 bits of the accumulator are added to a phase adjustment word and registered, and the result is presented as the lookup address.

A host loads holding registers over a 16-bit bus. The bus has a 2-bit slot address, an active-low select and a write strobe. Each holding register captures on the rising edge of the strobe. All other state runs on the system clock. Every datapath control input is active low, except the quadrant select and the half-range select. Each control is registered once by the clock, and only that registered copy acts. This gives every control exactly one cycle of latency.

The phase adjustment register can take one of two values. It can take the host-loaded phase word. It can also take a coarse quadrant step chosen by a 2-bit code, with the low 14 bits zero. A half-range mode forces the address MSB low, so the lookup repeats every 180 degrees.

Top module: `nco_phase_ctrl`

## Requirements
- R1: A clock edge with `rst` high clears every clocked register and every registered control to its inactive state. A strobe edge with `rst` high clears the host holding registers. After reset, `rom_addr` reads 0.
- R2: A rising edge on `host_wr` while `host_cs_n` is low stores `host_data` into the slot given by `host_addr`. Slot 0 is the phase word, slot 1 is frequency bits 15:0 and slot 2 is frequency bits 31:16. Slot 3 is ignored. A strobe while `host_cs_n` is high changes nothing.
- R3: The base register copies the 32-bit frequency holding value one clock after the edge that samples `center_en_n` low. Otherwise it holds.
- R4: The trim register copies the frequency holding value one clock after the edge that samples `offset_en_n` low. Otherwise it holds.
- R5: While the registered `acc_en_n` is low, the accumulator becomes its feedback term plus the base word plus the gated trim word, modulo 2^32. While it is high, the accumulator holds.
- R6: While the registered `offset_zero_n` is low, the trim term in the sum is zero. The trim register keeps its contents and can still be loaded.
- R7: While the registered `acc_load_n` is low, the feedback term is zero, so an enabled accumulator takes the frequency sum alone.
- R8: With the registered `quad_sel` high, the phase register loads {step,14'b0}. The step is 3 for code 00 (270°), 2 for 01 (180°), 1 for 10 (90°) and 0 for 11 (0°).
- R9: The phase register loads only while the registered `phase_en_n` is low. With `quad_sel` low, its source is the host phase word.
- R10: A clock edge registers the sum of accumulator bits 31:16 and the phase register, modulo 2^16. This registered sum is the address word.
- R11: While the registered `half_range` is high, bit 15 of `rom_addr` is 0 and bits 14:0 equal the registered address word. While it is low, `rom_addr` is that word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe, captures on rising edge |
| host_cs_n | input | 1 | Host select, active low |
| host_addr | input | 2 | Holding register slot |
| host_data | input | 16 | Host data bus |
| phase_en_n | input | 1 | Phase register load enable, active low |
| center_en_n | input | 1 | Base frequency register load enable, active low |
| offset_en_n | input | 1 | Trim frequency register load enable, active low |
| acc_en_n | input | 1 | Accumulator update enable, active low |
| offset_zero_n | input | 1 | Zero the trim term in the sum, active low |
| acc_load_n | input | 1 | Zero the accumulator feedback, active low |
| quad_sel | input | 1 | Phase source: 1 quadrant step, 0 host phase word |
| quad_code | input | 2 | Quadrant step code |
| half_range | input | 1 | Force address MSB low |
| rom_addr | output | 16 | Lookup address word |

## Verification
A wrong frequency or trim register does not show at the port right away. It appears as a growing drift in the address, one accumulator step after the first enabled update. That is up to three clocks after the control edge, plus however long the upper accumulator bits take to move. A wrong phase register shows as a constant offset two clocks after its load. A wrong half-range control shows as a bad MSB one clock after the control is sampled. The bench runs a cycle model built from the requirements and compares against it on every cycle. It also computes exact address values for the quadrant and zeroing cases by hand, so the faults that only drift slowly are still caught.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;

    typedef enum logic [1:0] {
        SLOT_PHASE   = 2'd0,
        SLOT_FREQ_LO = 2'd1,
        SLOT_FREQ_HI = 2'd2,
        SLOT_SPARE   = 2'd3
    } host_slot_e;

    typedef struct packed {
        logic       phase_en_n;
        logic       center_en_n;
        logic       offset_en_n;
        logic       acc_en_n;
        logic       offset_zero_n;
        logic       acc_load_n;
        logic       quad_sel;
        logic [1:0] quad_code;
        logic       half_range;
    } nco_ctrl_t;

    localparam nco_ctrl_t CTRL_IDLE = '{
        phase_en_n:    1'b1,
        center_en_n:   1'b1,
        offset_en_n:   1'b1,
        acc_en_n:      1'b1,
        offset_zero_n: 1'b1,
        acc_load_n:    1'b1,
        quad_sel:      1'b0,
        quad_code:     2'b00,
        half_range:    1'b0
    };

    // quadrant code to step count: 00->3, 01->2, 10->1, 11->0
    function automatic logic [1:0] quad_step(input logic [1:0] code);
        return ~code;
    endfunction

endpackage

// File: rtl/nco_host_regs.sv
`timescale 1ns/1ps
module nco_host_regs #(
    parameter int BUS_W = 16
) (
    input  logic                 host_wr,
    input  logic                 rst,
    input  logic                 host_cs_n,
    input  logic [1:0]           host_addr,
    input  logic [BUS_W-1:0]     host_data,
    output logic [BUS_W-1:0]     phase_hold,
    output logic [2*BUS_W-1:0]   freq_hold
);
    import nco_pkg::*;

    always_ff @(posedge host_wr) begin
        if (rst) begin
            phase_hold <= '0;
            freq_hold  <= '0;
        end else if (!host_cs_n) begin
            unique case (host_slot_e'(host_addr))
                SLOT_PHASE:   phase_hold             <= host_data;
                SLOT_FREQ_LO: freq_hold[BUS_W-1:0]   <= host_data;
                SLOT_FREQ_HI: freq_hold[2*BUS_W-1:BUS_W] <= host_data;
                SLOT_SPARE:   ;
            endcase
        end
    end

endmodule

// File: rtl/nco_ctrl_sync.sv
`timescale 1ns/1ps
module nco_ctrl_sync (
    input  logic              clk,
    input  logic              rst,
    input  nco_pkg::nco_ctrl_t ctrl_in,
    output nco_pkg::nco_ctrl_t ctrl_q
);
    import nco_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_IDLE;
        else     ctrl_q <= ctrl_in;
    end

endmodule

// File: rtl/nco_freq_acc.sv
`timescale 1ns/1ps
module nco_freq_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             center_en_q,
    input  logic             offset_en_q,
    input  logic             acc_en_q,
    input  logic             offset_zero_q,
    input  logic             acc_load_q,
    input  logic [ACC_W-1:0] freq_hold,
    output logic [ACC_W-1:0] center_reg,
    output logic [ACC_W-1:0] offset_reg,
    output logic [ACC_W-1:0] acc_reg
);
    logic [ACC_W-1:0] offset_term;
    logic [ACC_W-1:0] feedback;
    logic [ACC_W-1:0] acc_next;

    always_comb begin
        offset_term = offset_zero_q ? offset_reg : '0;
        feedback    = acc_load_q ? acc_reg : '0;
        acc_next    = feedback + center_reg + offset_term;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            center_reg <= '0;
            offset_reg <= '0;
            acc_reg    <= '0;
        end else begin
            if (!center_en_q) center_reg <= freq_hold;
            if (!offset_en_q) offset_reg <= freq_hold;
            if (!acc_en_q)    acc_reg    <= acc_next;
        end
    end

endmodule

// File: rtl/nco_phase_out.sv
`timescale 1ns/1ps
module nco_phase_out #(
    parameter int PH_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            phase_en_q,
    input  logic            quad_sel_q,
    input  logic [1:0]      quad_code_q,
    input  logic            half_q,
    input  logic [PH_W-1:0] phase_hold,
    input  logic [PH_W-1:0] acc_top,
    output logic [PH_W-1:0] phase_reg,
    output logic [PH_W-1:0] rom_addr
);
    import nco_pkg::*;

    localparam int LOW_W = PH_W - 2;

    logic [PH_W-1:0] phase_src;
    logic [PH_W-1:0] addr_q;

    always_comb begin
        phase_src = quad_sel_q ? {quad_step(quad_code_q), {LOW_W{1'b0}}} : phase_hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_reg <= '0;
            addr_q    <= '0;
        end else begin
            if (!phase_en_q) phase_reg <= phase_src;
            addr_q <= acc_top + phase_reg;
        end
    end

    always_comb begin
        rom_addr = half_q ? {1'b0, addr_q[PH_W-2:0]} : addr_q;
    end

endmodule

// File: rtl/nco_phase_ctrl.sv
`timescale 1ns/1ps
module nco_phase_ctrl #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_cs_n,
    input  logic [1:0]       host_addr,
    input  logic [BUS_W-1:0] host_data,
    input  logic             phase_en_n,
    input  logic             center_en_n,
    input  logic             offset_en_n,
    input  logic             acc_en_n,
    input  logic             offset_zero_n,
    input  logic             acc_load_n,
    input  logic             quad_sel,
    input  logic [1:0]       quad_code,
    input  logic             half_range,
    output logic [BUS_W-1:0] rom_addr
);
    import nco_pkg::*;

    localparam int ACC_W = 2 * BUS_W;
    localparam int PH_W  = BUS_W;

    nco_ctrl_t        ctrl_in;
    nco_ctrl_t        ctrl_q;
    logic [PH_W-1:0]  phase_hold;
    logic [ACC_W-1:0] freq_hold;
    logic [ACC_W-1:0] center_reg;
    logic [ACC_W-1:0] offset_reg;
    logic [ACC_W-1:0] acc_reg;
    logic [PH_W-1:0]  phase_reg;

    always_comb begin
        ctrl_in.phase_en_n    = phase_en_n;
        ctrl_in.center_en_n   = center_en_n;
        ctrl_in.offset_en_n   = offset_en_n;
        ctrl_in.acc_en_n      = acc_en_n;
        ctrl_in.offset_zero_n = offset_zero_n;
        ctrl_in.acc_load_n    = acc_load_n;
        ctrl_in.quad_sel      = quad_sel;
        ctrl_in.quad_code     = quad_code;
        ctrl_in.half_range    = half_range;
    end

    nco_host_regs #(.BUS_W(BUS_W)) u_host (
        .host_wr    (host_wr),
        .rst        (rst),
        .host_cs_n  (host_cs_n),
        .host_addr  (host_addr),
        .host_data  (host_data),
        .phase_hold (phase_hold),
        .freq_hold  (freq_hold)
    );

    nco_ctrl_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .ctrl_in (ctrl_in),
        .ctrl_q  (ctrl_q)
    );

    nco_freq_acc #(.ACC_W(ACC_W)) u_acc (
        .clk           (clk),
        .rst           (rst),
        .center_en_q   (ctrl_q.center_en_n),
        .offset_en_q   (ctrl_q.offset_en_n),
        .acc_en_q      (ctrl_q.acc_en_n),
        .offset_zero_q (ctrl_q.offset_zero_n),
        .acc_load_q    (ctrl_q.acc_load_n),
        .freq_hold     (freq_hold),
        .center_reg    (center_reg),
        .offset_reg    (offset_reg),
        .acc_reg       (acc_reg)
    );

    nco_phase_out #(.PH_W(PH_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .phase_en_q  (ctrl_q.phase_en_n),
        .quad_sel_q  (ctrl_q.quad_sel),
        .quad_code_q (ctrl_q.quad_code),
        .half_q      (ctrl_q.half_range),
        .phase_hold  (phase_hold),
        .acc_top     (acc_reg[ACC_W-1 -: PH_W]),
        .phase_reg   (phase_reg),
        .rom_addr    (rom_addr)
    );

endmodule

// File: rtl/nco_phase_ctrl_checker.sv
`timescale 1ns/1ps
module nco_phase_ctrl_checker #(
    parameter int BUS_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               half_range,
    input logic [BUS_W-1:0]   rom_addr,
    input logic               center_en_q,
    input logic               offset_en_q,
    input logic               acc_en_q,
    input logic               offset_zero_q,
    input logic               acc_load_q,
    input logic               phase_en_q,
    input logic               quad_sel_q,
    input logic [2*BUS_W-1:0] center_reg,
    input logic [2*BUS_W-1:0] offset_reg,
    input logic [2*BUS_W-1:0] acc_reg,
    input logic [BUS_W-1:0]   phase_reg
);
    localparam int LOW_W = BUS_W - 2;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (rom_addr == '0));

    assert_center_hold_R3: assert property (@(posedge clk) disable iff (rst)
        center_en_q |=> $stable(center_reg));

    assert_offset_hold_R4: assert property (@(posedge clk) disable iff (rst)
        offset_en_q |=> $stable(offset_reg));

    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        acc_en_q |=> $stable(acc_reg));

    assert_load_base_only_R7: assert property (@(posedge clk) disable iff (rst)
        (!acc_en_q && !acc_load_q && !offset_zero_q) |=> (acc_reg == $past(center_reg)));

    assert_quad_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (!phase_en_q && quad_sel_q) |=> (phase_reg[LOW_W-1:0] == '0));

    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
        phase_en_q |=> $stable(phase_reg));

    assert_half_msb_R11: assert property (@(posedge clk) disable iff (rst)
        $past(half_range) |-> !rom_addr[BUS_W-1]);

endmodule

bind nco_phase_ctrl nco_phase_ctrl_checker #(.BUS_W(BUS_W)) u_checker (
    .clk           (clk),
    .rst           (rst),
    .half_range    (half_range),
    .rom_addr      (rom_addr),
    .center_en_q   (ctrl_q.center_en_n),
    .offset_en_q   (ctrl_q.offset_en_n),
    .acc_en_q      (ctrl_q.acc_en_n),
    .offset_zero_q (ctrl_q.offset_zero_n),
    .acc_load_q    (ctrl_q.acc_load_n),
    .phase_en_q    (ctrl_q.phase_en_n),
    .quad_sel_q    (ctrl_q.quad_sel),
    .center_reg    (center_reg),
    .offset_reg    (offset_reg),
    .acc_reg       (acc_reg),
    .phase_reg     (phase_reg)
);

// File: tb/nco_phase_ctrl_bench.sv
`timescale 1ns/1ps
module nco_phase_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_cs_n = 1'b1;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_data = 16'd0;
    logic        phase_en_n = 1'b1;
    logic        center_en_n = 1'b1;
    logic        offset_en_n = 1'b1;
    logic        acc_en_n = 1'b1;
    logic        offset_zero_n = 1'b1;
    logic        acc_load_n = 1'b1;
    logic        quad_sel = 1'b0;
    logic [1:0]  quad_code = 2'd0;
    logic        half_range = 1'b0;
    logic [15:0] rom_addr;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    nco_phase_ctrl u_nco_phase_ctrl (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_cs_n(host_cs_n),
        .host_addr(host_addr), .host_data(host_data), .phase_en_n(phase_en_n),
        .center_en_n(center_en_n), .offset_en_n(offset_en_n), .acc_en_n(acc_en_n),
        .offset_zero_n(offset_zero_n), .acc_load_n(acc_load_n), .quad_sel(quad_sel),
        .quad_code(quad_code), .half_range(half_range), .rom_addr(rom_addr)
    );

    // cycle model written from the requirements
    logic [15:0] m_phold, m_phase, m_addr;
    logic [31:0] m_fhold, m_base, m_trim, m_acc;
    logic m_pen, m_cen, m_oen, m_aen, m_oz, m_ald, m_qs, m_half;
    logic [1:0] m_qc;

    always @(posedge host_wr) begin
        if (rst) begin
            m_phold <= 16'd0;
            m_fhold <= 32'd0;
        end else if (!host_cs_n) begin
            if (host_addr == 2'd0) m_phold <= host_data;
            if (host_addr == 2'd1) m_fhold[15:0] <= host_data;
            if (host_addr == 2'd2) m_fhold[31:16] <= host_data;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            {m_pen, m_cen, m_oen, m_aen, m_oz, m_ald} <= 6'b111111;
            m_qs <= 1'b0; m_qc <= 2'd0; m_half <= 1'b0;
            m_base <= 32'd0; m_trim <= 32'd0; m_acc <= 32'd0;
            m_phase <= 16'd0; m_addr <= 16'd0;
        end else begin
            {m_pen, m_cen, m_oen, m_aen, m_oz, m_ald} <=
                {phase_en_n, center_en_n, offset_en_n, acc_en_n, offset_zero_n, acc_load_n};
            m_qs <= quad_sel; m_qc <= quad_code; m_half <= half_range;
            if (m_cen == 1'b0) m_base <= m_fhold;
            if (m_oen == 1'b0) m_trim <= m_fhold;
            if (m_aen == 1'b0)
                m_acc <= (m_ald ? m_acc : 32'd0) + m_base + (m_oz ? m_trim : 32'd0);
            if (m_pen == 1'b0)
                m_phase <= m_qs ? (16'd3 - {14'd0, m_qc}) << 14 : m_phold;
            m_addr <= m_acc[31:16] + m_phase;
        end
    end

    task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rom_addr actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !finished)
            check_val(cur_req, rom_addr, m_half ? {1'b0, m_addr[14:0]} : m_addr);
    end

    task automatic host_write(input logic [1:0] a, input logic [15:0] d, input logic cs_n);
        @(negedge clk);
        host_addr = a; host_data = d; host_cs_n = cs_n;
        #0.5 host_wr = 1'b1;
        #1.0 host_wr = 1'b0;
        #0.5 host_cs_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_center_offset(input logic c, input logic o);
        @(negedge clk);
        center_en_n = ~c; offset_en_n = ~o;
        @(negedge clk);
        center_en_n = 1'b1; offset_en_n = 1'b1;
    endtask

    task automatic acc_step(input logic load, input logic zero_trim);
        @(negedge clk);
        acc_en_n = 1'b0; acc_load_n = ~load; offset_zero_n = ~zero_trim;
        @(negedge clk);
        acc_en_n = 1'b1; acc_load_n = 1'b1; offset_zero_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R1: reset both clock domains
        #1 host_wr = 1'b1; #1 host_wr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        check_val("R1", rom_addr, 16'h0000);
        checking = 1'b1;

        // R2: selected writes land, deselected and spare-slot writes do not
        cur_req = "R2";
        host_write(2'd0, 16'h1234, 1'b0);
        host_write(2'd0, 16'h5555, 1'b1);
        host_write(2'd3, 16'hFFFF, 1'b0);
        @(negedge clk); phase_en_n = 1'b0;
        @(negedge clk); phase_en_n = 1'b1;
        idle(3);
        check_val("R2", rom_addr, 16'h1234);

        // R3/R10: base word 0x0001_0000 loaded, one loading step
        cur_req = "R3";
        host_write(2'd1, 16'h0000, 1'b0);
        host_write(2'd2, 16'h0001, 1'b0);
        host_write(2'd2, 16'h0077, 1'b1);
        pulse_center_offset(1'b1, 1'b0);
        cur_req = "R10";
        acc_step(1'b1, 1'b0);
        idle(3);
        check_val("R10", rom_addr, 16'h1235);

        // R4/R6: trim word 0x0003_0000; zeroed trim then live trim
        cur_req = "R4";
        host_write(2'd2, 16'h0003, 1'b0);
        pulse_center_offset(1'b0, 1'b1);
        cur_req = "R6";
        acc_step(1'b1, 1'b1);
        idle(3);
        check_val("R6", rom_addr, 16'h1235);
        acc_step(1'b1, 1'b0);
        idle(3);
        check_val("R4", rom_addr, 16'h1238);

        // R5: two accumulating steps add 0x0004 each to the top half
        cur_req = "R5";
        acc_step(1'b0, 1'b0);
        acc_step(1'b0, 1'b0);
        idle(3);
        check_val("R5", rom_addr, 16'h1240);

        // R7: loading step discards feedback
        cur_req = "R7";
        acc_step(1'b1, 1'b0);
        idle(3);
        check_val("R7", rom_addr, 16'h1238);

        // zero the accumulator: base and trim to 0, loading step
        host_write(2'd2, 16'h0000, 1'b0);
        pulse_center_offset(1'b1, 1'b1);
        acc_step(1'b1, 1'b0);
        idle(3);

        // R8/R11: quadrant sweep, both range modes
        for (int h = 0; h < 2; h++) begin
            for (int c = 0; c < 4; c++) begin
                cur_req = "R8";
                @(negedge clk);
                quad_sel = 1'b1; quad_code = 2'(c); phase_en_n = 1'b0; half_range = h[0];
                idle(4);
                check_val(h ? "R11" : "R8", rom_addr,
                          h ? ((16'(3 - c) << 14) & 16'h7FFF) : (16'(3 - c) << 14));
            end
        end
        @(negedge clk); phase_en_n = 1'b1; quad_sel = 1'b0; half_range = 1'b0;

        // R9: phase enable high blocks a new phase word
        cur_req = "R9";
        host_write(2'd0, 16'h0F0F, 1'b0);
        idle(4);
        check_val("R9", rom_addr, 16'h0000);
        @(negedge clk); phase_en_n = 1'b0;
        @(negedge clk); phase_en_n = 1'b1;
        idle(3);
        check_val("R9", rom_addr, 16'h0F0F);

        // sweep: R2/R3/R4/R5/R6/R7/R8/R9/R11 against the cycle model
        cur_req = "R2/R3/R4/R5/R6/R7/R8/R9/R11 sweep";
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 3 == 0) host_write(lfsr[1:0], lfsr ^ 16'h3C5A, lfsr[5] & lfsr[6]);
            @(negedge clk);
            phase_en_n    = lfsr[2];
            center_en_n   = lfsr[3] | lfsr[9];
            offset_en_n   = lfsr[4] | lfsr[11];
            acc_en_n      = lfsr[7] & lfsr[8];
            offset_zero_n = lfsr[10];
            acc_load_n    = lfsr[12] | lfsr[13];
            quad_sel      = lfsr[14];
            quad_code     = lfsr[1:0] ^ lfsr[9:8];
            half_range    = lfsr[15] & lfsr[3];
        end
        idle(4);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule